// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block performs the entry half of exception handling for a classic RISC pipeline with branch delay slots. When the core raises a request, it presents a kind, a 5-bit exception code, the PC of the faulting instruction, a flag saying whether that instruction sat in a delay slot, and its current status bits. On the next clock edge the block commits the saved return address, the cause fields, the updated status bits and the new fetch address. It also pulses a valid flag for that fetch address.

There are three entry paths. Reset and non-maskable interrupt share the error path. Debug entry has its own path. Interrupts, translation refills and all other faults take the general path. The saved address is one instruction earlier when the fault came from a delay slot, so that the branch runs again. A general exception raised while already at exception level leaves the saved address and the delay bit alone. The handler vector depends on the boot-vector bit, an exception base input, the request kind and an interrupt-vector enable.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Synchronous active-high `rst` clears every output to zero. After release the outputs hold until the first request.
- R2: The request kind encoding is 0 reset, 1 non-maskable interrupt, 2 debug, 3 external interrupt, 4 translation refill, and 5 general. Codes 6 and 7 are also handled as general. Kinds 3, 4 and 5 take the general path. A general-path request with `stat_exl` low stores `req_pc` in `epc_o`, or `req_pc`-4 when `req_in_delay` is high, and copies `req_in_delay` into cause bit 31.
- R3: A general-path request with `stat_exl` high leaves `epc_o` and cause bit 31 unchanged.
- R4: A general-path request sets `exl_o` and clears `user_o`. `erl_o`, `bev_o` and `dbg_o` take the values of the matching status inputs.
- R5: A general-path request writes its code into cause bits 6:2. An external interrupt writes code 0 and ignores `req_code`. All other cause bits stay zero.
- R6: The general vector base is 0xBFC00200 when `stat_bev` is high. Otherwise it is `ebase` with bits 9:0 cleared.
- R7: The offset added to the base is 0x000 for a refill taken with `stat_exl` low, and 0x200 for an external interrupt when `cause_iv` is high. Every other general-path request uses 0x180.
- R8: Reset and non-maskable interrupt store `req_pc`, or `req_pc`-4 in a delay slot, in `error_pc_o`. They set `erl_o` and `bev_o`, clear `user_o`, leave `epc_o` unchanged, and fetch from 0xBFC00000.
- R9: Debug entry stores `req_pc`, or `req_pc`-4 in a delay slot, in `debug_pc_o`. It sets `dbg_o`, clears `user_o`, and fetches from 0xBFC00480.
- R10: An external interrupt raised while `stat_dbg` is high takes the debug path and leaves the cause code unchanged.
- R11: Error-path and debug-path entries clear cause bit 31 when `stat_exl` is low and keep it when `stat_exl` is high.
- R12: `fetch_valid` is high for exactly the one cycle after a request, and `fetch_pc` is updated at the same edge. Without a request, all registered outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request strobe |
| req_kind | input | 3 | Request kind (encoding in R2) |
| req_code | input | 5 | Exception code for the general path |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_delay | input | 1 | Faulting instruction was in a delay slot |
| stat_exl | input | 1 | Current exception-level bit |
| stat_erl | input | 1 | Current error-level bit |
| stat_bev | input | 1 | Current boot-vector bit |
| stat_user | input | 1 | Core currently in user mode |
| stat_dbg | input | 1 | Core currently in debug mode |
| cause_iv | input | 1 | Interrupts use the dedicated offset |
| ebase | input | 32 | Exception base address |
| fetch_valid | output | 1 | New fetch address is valid this cycle |
| fetch_pc | output | 32 | Handler fetch address |
| epc_o | output | 32 | Saved exception PC |
| error_pc_o | output | 32 | Saved error PC |
| debug_pc_o | output | 32 | Saved debug PC |
| cause_o | output | 32 | Cause register (bit 31 delay, bits 6:2 code) |
| exl_o | output | 1 | Updated exception-level bit |
| erl_o | output | 1 | Updated error-level bit |
| bev_o | output | 1 | Updated boot-vector bit |
| user_o | output | 1 | Updated user-mode flag |
| dbg_o | output | 1 | Updated debug-mode flag |

## Verification
The assertions assume that the status inputs are stable and meaningful during the cycle in which `req_valid` is high. They compare each registered result against the request and status values sampled one cycle earlier. They also assume that `req_kind` never changes the class of a pending entry except through `stat_dbg`.

The bench drives all inputs on the falling edge and holds `req_valid` for exactly one cycle. It resets the block before each scenario, so that every expected value follows only from the inputs of that scenario. It changes status inputs only while no request is pending.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    parameter int XLEN        = 32;
    parameter int CODE_W      = 5;
    parameter int KIND_W      = 3;
    parameter int INSN_BYTES  = 4;
    parameter int BD_BIT      = 31;
    parameter int CODE_LSB    = 2;
    parameter int EBASE_ALIGN = 10;

    localparam logic [XLEN-1:0] VEC_ERROR     = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] VEC_DEBUG     = 32'hBFC0_0480;
    localparam logic [XLEN-1:0] VEC_BOOT_BASE = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] OFF_REFILL    = 32'h0000_0000;
    localparam logic [XLEN-1:0] OFF_GENERAL   = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFF_IRQ       = 32'h0000_0200;
    localparam logic [XLEN-1:0] BASE_MASK     =
        ~(XLEN'((64'd1 << EBASE_ALIGN) - 64'd1));

    localparam logic [KIND_W-1:0] K_RESET  = 3'd0;
    localparam logic [KIND_W-1:0] K_NMI    = 3'd1;
    localparam logic [KIND_W-1:0] K_DEBUG  = 3'd2;
    localparam logic [KIND_W-1:0] K_IRQ    = 3'd3;
    localparam logic [KIND_W-1:0] K_REFILL = 3'd4;

    typedef enum logic [1:0] {
        CLS_ERR = 2'd0,
        CLS_DBG = 2'd1,
        CLS_GEN = 2'd2
    } exc_class_e;

    typedef struct packed {
        logic exl;
        logic erl;
        logic bev;
        logic user;
        logic dbg;
    } stat_t;

    typedef struct packed {
        exc_class_e        cls;
        logic              refill;
        logic              irq;
        logic [CODE_W-1:0] code;
    } exc_dec_t;

    function automatic logic [XLEN-1:0] restart_pc(
        input logic [XLEN-1:0] pc,
        input logic            in_delay
    );
        return in_delay ? (pc - XLEN'(INSN_BYTES)) : pc;
    endfunction

    function automatic logic [XLEN-1:0] align_base(input logic [XLEN-1:0] b);
        return b & BASE_MASK;
    endfunction

endpackage

// File: rtl/exc_kind_decode.sv
module exc_kind_decode
    import exc_entry_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [CODE_W-1:0] code,
    input  logic              in_dbg,
    output exc_dec_t          dec
);
    always_comb begin
        dec.cls    = CLS_GEN;
        dec.refill = 1'b0;
        dec.irq    = 1'b0;
        dec.code   = code;
        case (kind)
            K_RESET, K_NMI: dec.cls = CLS_ERR;
            K_DEBUG:        dec.cls = CLS_DBG;
            K_IRQ: begin
                if (in_dbg) begin
                    dec.cls = CLS_DBG;
                end else begin
                    dec.irq  = 1'b1;
                    dec.code = '0;
                end
            end
            K_REFILL:       dec.refill = 1'b1;
            default:        dec.cls = CLS_GEN;
        endcase
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_entry_pkg::*;
(
    input  exc_dec_t        dec,
    input  logic            bev,
    input  logic            exl,
    input  logic            iv,
    input  logic [XLEN-1:0] ebase,
    output logic [XLEN-1:0] vec
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base = bev ? VEC_BOOT_BASE : align_base(ebase);
        if (dec.refill && !exl)
            offset = OFF_REFILL;
        else if (dec.irq && iv)
            offset = OFF_IRQ;
        else
            offset = OFF_GENERAL;

        unique case (dec.cls)
            CLS_ERR: vec = VEC_ERROR;
            CLS_DBG: vec = VEC_DEBUG;
            default: vec = base + offset;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [CODE_W-1:0] req_code,
    input  logic [XLEN-1:0]   req_pc,
    input  logic              req_in_delay,
    input  logic              stat_exl,
    input  logic              stat_erl,
    input  logic              stat_bev,
    input  logic              stat_user,
    input  logic              stat_dbg,
    input  logic              cause_iv,
    input  logic [XLEN-1:0]   ebase,
    output logic              fetch_valid,
    output logic [XLEN-1:0]   fetch_pc,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   error_pc_o,
    output logic [XLEN-1:0]   debug_pc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic              exl_o,
    output logic              erl_o,
    output logic              bev_o,
    output logic              user_o,
    output logic              dbg_o
);
    exc_dec_t        dec;
    logic [XLEN-1:0] vec;
    logic [XLEN-1:0] saved_pc;
    stat_t           stat_in;
    stat_t           stat_nx;
    stat_t           stat_q;

    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   err_q;
    logic [XLEN-1:0]   dbgpc_q;
    logic              bd_q;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   fpc_q;
    logic              fv_q;

    exc_kind_decode u_dec (
        .kind   (req_kind),
        .code   (req_code),
        .in_dbg (stat_dbg),
        .dec    (dec)
    );

    exc_vector_gen u_vec (
        .dec   (dec),
        .bev   (stat_bev),
        .exl   (stat_exl),
        .iv    (cause_iv),
        .ebase (ebase),
        .vec   (vec)
    );

    assign saved_pc = restart_pc(req_pc, req_in_delay);
    assign stat_in  = '{exl: stat_exl, erl: stat_erl, bev: stat_bev,
                        user: stat_user, dbg: stat_dbg};

    always_comb begin
        stat_nx      = stat_in;
        stat_nx.user = 1'b0;
        unique case (dec.cls)
            CLS_ERR: begin
                stat_nx.erl = 1'b1;
                stat_nx.bev = 1'b1;
            end
            CLS_DBG: stat_nx.dbg = 1'b1;
            default: stat_nx.exl = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            err_q   <= '0;
            dbgpc_q <= '0;
            bd_q    <= 1'b0;
            code_q  <= '0;
            fpc_q   <= '0;
            fv_q    <= 1'b0;
            stat_q  <= '0;
        end else begin
            fv_q <= req_valid;
            if (req_valid) begin
                fpc_q  <= vec;
                stat_q <= stat_nx;
                unique case (dec.cls)
                    CLS_ERR: begin
                        err_q <= saved_pc;
                        if (!stat_exl) bd_q <= 1'b0;
                    end
                    CLS_DBG: begin
                        dbgpc_q <= saved_pc;
                        if (!stat_exl) bd_q <= 1'b0;
                    end
                    default: begin
                        code_q <= dec.code;
                        if (!stat_exl) begin
                            epc_q <= saved_pc;
                            bd_q  <= req_in_delay;
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        cause_o                      = '0;
        cause_o[BD_BIT]              = bd_q;
        cause_o[CODE_LSB +: CODE_W]  = code_q;
    end

    assign fetch_valid = fv_q;
    assign fetch_pc    = fpc_q;
    assign epc_o       = epc_q;
    assign error_pc_o  = err_q;
    assign debug_pc_o  = dbgpc_q;
    assign exl_o       = stat_q.exl;
    assign erl_o       = stat_q.erl;
    assign bev_o       = stat_q.bev;
    assign user_o      = stat_q.user;
    assign dbg_o       = stat_q.dbg;

    // R3
    nested_epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.cls == CLS_GEN && stat_exl)
            |=> ($stable(epc_o) && $stable(cause_o[BD_BIT])));

    // R4
    gen_sets_exl_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.cls == CLS_GEN) |=> (exl_o && !user_o));

    // R8
    err_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.cls == CLS_ERR)
            |=> (erl_o && bev_o && !user_o && fetch_pc == VEC_ERROR && $stable(epc_o)));

    // R9
    dbg_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.cls == CLS_DBG)
            |=> (dbg_o && !user_o && fetch_pc == VEC_DEBUG));

    // R12
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> fetch_valid);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!fetch_valid && $stable(fetch_pc) && $stable(epc_o)
                        && $stable(cause_o)));

    // R2
    gen_epc_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.cls == CLS_GEN && !stat_exl)
            |=> (cause_o[BD_BIT] == $past(req_in_delay)));

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [4:0]  req_code;
    logic [31:0] req_pc;
    logic        req_in_delay;
    logic        stat_exl, stat_erl, stat_bev, stat_user, stat_dbg;
    logic        cause_iv;
    logic [31:0] ebase;
    logic        fetch_valid;
    logic [31:0] fetch_pc, epc_o, error_pc_o, debug_pc_o, cause_o;
    logic        exl_o, erl_o, bev_o, user_o, dbg_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_code(req_code), .req_pc(req_pc), .req_in_delay(req_in_delay),
        .stat_exl(stat_exl), .stat_erl(stat_erl), .stat_bev(stat_bev),
        .stat_user(stat_user), .stat_dbg(stat_dbg), .cause_iv(cause_iv),
        .ebase(ebase), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .epc_o(epc_o), .error_pc_o(error_pc_o), .debug_pc_o(debug_pc_o),
        .cause_o(cause_o), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o),
        .user_o(user_o), .dbg_o(dbg_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_stat(input logic exl, input logic erl, input logic bev,
                            input logic usr, input logic dbg);
        stat_exl = exl; stat_erl = erl; stat_bev = bev;
        stat_user = usr; stat_dbg = dbg;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; req_kind = 3'd0; req_code = '0;
        req_pc = '0; req_in_delay = 1'b0; cause_iv = 1'b0; ebase = 32'h8000_0000;
        set_stat(0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fire(input logic [2:0] kind, input logic [4:0] code,
                        input logic [31:0] pc, input logic ds);
        req_kind = kind; req_code = code; req_pc = pc; req_in_delay = ds;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 fetch_valid", {31'b0, fetch_valid}, 32'd0);
        chk("R1 fetch_pc", fetch_pc, 32'd0);
        chk("R1 epc", epc_o, 32'd0);
        chk("R1 cause", cause_o, 32'd0);
        chk("R1 status", {27'b0, exl_o, erl_o, bev_o, user_o, dbg_o}, 32'd0);
    endtask

    task automatic t_general_plain();
        do_reset();
        set_stat(0, 0, 0, 1, 0);
        fire(3'd5, 5'd4, 32'h0000_1000, 1'b0);
        chk("R2 epc", epc_o, 32'h0000_1000);
        chk("R5 cause", cause_o, 32'h0000_0010);
        chk("R7 general offset", fetch_pc, 32'h8000_0180);
        chk("R4 exl/user", {30'b0, exl_o, user_o}, 32'd2);
        chk("R12 pulse high", {31'b0, fetch_valid}, 32'd1);
        @(negedge clk);
        chk("R12 pulse low", {31'b0, fetch_valid}, 32'd0);
        chk("R12 hold epc", epc_o, 32'h0000_1000);
    endtask

    task automatic t_general_delay_nested();
        do_reset();
        set_stat(0, 0, 1, 0, 0);
        fire(3'd7, 5'd10, 32'h0000_2004, 1'b1);
        chk("R2 delay epc", epc_o, 32'h0000_2000);
        chk("R2 delay cause", cause_o, 32'h8000_0028);
        chk("R6 boot base", fetch_pc, 32'hBFC0_0380);
        chk("R4 bev passthrough", {31'b0, bev_o}, 32'd1);
        set_stat(1, 0, 0, 0, 0);
        fire(3'd5, 5'd3, 32'h0000_5000, 1'b0);
        chk("R3 nested epc", epc_o, 32'h0000_2000);
        chk("R3 nested cause", cause_o, 32'h8000_000C);
        chk("R6 ebase base", fetch_pc, 32'h8000_0180);
    endtask

    task automatic t_refill();
        do_reset();
        ebase = 32'h9000_03FF;
        fire(3'd4, 5'd2, 32'h0000_0040, 1'b0);
        chk("R7 refill offset", fetch_pc, 32'h9000_0000);
        set_stat(1, 0, 0, 0, 0);
        fire(3'd4, 5'd2, 32'h0000_0040, 1'b0);
        chk("R7 refill nested", fetch_pc, 32'h9000_0180);
    endtask

    task automatic t_irq();
        do_reset();
        cause_iv = 1'b1;
        fire(3'd3, 5'd7, 32'h0000_0100, 1'b0);
        chk("R7 irq iv", fetch_pc, 32'h8000_0200);
        chk("R5 irq code zero", cause_o, 32'h0000_0000);
        do_reset();
        fire(3'd3, 5'd7, 32'h0000_0100, 1'b0);
        chk("R7 irq no iv", fetch_pc, 32'h8000_0180);
    endtask

    task automatic t_error_path();
        do_reset();
        fire(3'd5, 5'd4, 32'h0000_1004, 1'b1);
        set_stat(1, 0, 0, 1, 0);
        fire(3'd1, 5'd9, 32'h0000_4000, 1'b0);
        chk("R8 nmi error_pc", error_pc_o, 32'h0000_4000);
        chk("R11 nmi bd kept", cause_o, 32'h8000_0010);
        chk("R8 nmi fetch", fetch_pc, 32'hBFC0_0000);
        chk("R8 nmi status", {27'b0, exl_o, erl_o, bev_o, user_o, dbg_o}, 32'b11100);
        set_stat(0, 0, 0, 0, 0);
        fire(3'd0, 5'd9, 32'h0000_3008, 1'b1);
        chk("R8 reset error_pc", error_pc_o, 32'h0000_3004);
        chk("R8 epc unchanged", epc_o, 32'h0000_1000);
        chk("R11 reset bd cleared", cause_o, 32'h0000_0010);
    endtask

    task automatic t_debug();
        do_reset();
        set_stat(0, 0, 0, 1, 0);
        fire(3'd2, 5'd1, 32'h0000_6000, 1'b1);
        chk("R9 debug_pc", debug_pc_o, 32'h0000_5FFC);
        chk("R9 fetch", fetch_pc, 32'hBFC0_0480);
        chk("R9 dbg/user", {30'b0, dbg_o, user_o}, 32'd2);
        do_reset();
        fire(3'd5, 5'd6, 32'h0000_0010, 1'b0);
        set_stat(0, 0, 0, 0, 1);
        fire(3'd3, 5'd0, 32'h0000_7000, 1'b0);
        chk("R10 irq in debug pc", debug_pc_o, 32'h0000_7000);
        chk("R10 irq in debug fetch", fetch_pc, 32'hBFC0_0480);
        chk("R10 cause code kept", cause_o, 32'h0000_0018);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        t_reset_state();
        t_general_plain();
        t_general_delay_nested();
        t_refill();
        t_irq();
        t_error_path();
        t_debug();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule